// File: doc/BRIEF.md
# Vertical pattern line sequencer

This block drives the eight vertical clock outputs of an image-sensor readout line. At every line-start strobe it latches which stored pattern to use, how many passes of it to play, and whether the line is a sensor-gate line. It then plays the pattern the requested number of times. A pattern holds a start polarity for each output, two toggle positions for each output and a length. Odd and even lines use separate repeat counts but always the same pattern.

On a sensor-gate line a second pattern is selected on its own. Once the first group has finished, the second pattern starts as soon as the incoming pixel counter reaches that pattern's length value, which in this case serves as a start pixel. The second pattern plays exactly once and runs until the next line start. Pattern contents are loaded through a narrow write port into a small register array.

Top module: `vpat_line_seq`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_data` into pattern `cfg_pat` at the rising edge. Index 0..15 is a toggle position: output `idx>>1`, slot `idx&1`. Index 16 is the start polarity vector (low 8 bits). Index 17 is the length. Other index values change nothing.
- R2: A pass of pattern p lasts max(len,1) cycles. In the cycle after a line-start edge the outputs equal p's start polarity. At pass offset o, output j equals its start polarity inverted once for each of its toggle positions t with 1 <= t <= o. Each new pass restarts at offset 0.
- R3: `line_odd` is 1 after reset. A line start with `field_start` high makes the line odd. Any other line start takes the opposite parity of the previous line, except that a `field_start` without a line start forces the next line to be odd.
- R4: On odd lines `rep_odd` passes are played and on even lines `rep_even` passes, all of the pattern chosen by `sel_first`. After the last pass the outputs hold that pattern's start polarity.
- R5: A repeat count of zero plays no first-group pass. The outputs take and hold the start polarity of the selected pattern from the line start onward.
- R6: On a line latched with `sg_line` high, pattern `sel_second` starts at its start polarity one cycle after the first cycle that has the first group finished and `pix` >= that pattern's length value.
- R7: The second pattern is never restarted. Its offset counts up from 0, one per cycle, saturating at 1023, until the next line start, and the toggle rule of R2 applies to it.
- R8: A line start at any point aborts the current sequence and begins a new line.
- R9: After reset the outputs are all 0 and no sequence runs until the first line start.
- R10: `sel_first`, `sel_second`, `rep_odd`, `rep_even` and `sg_line` are sampled only at a line start. Later changes within the line have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| field_start | input | 1 | Field start, forces odd parity |
| line_start | input | 1 | Line start strobe |
| pix | input | 10 | Pixel counter of the line |
| sg_line | input | 1 | Line carries sensor-gate pulses |
| sel_first | input | 2 | Pattern for the first group |
| sel_second | input | 2 | Pattern for the second group |
| rep_odd | input | 4 | Pass count on odd lines |
| rep_even | input | 4 | Pass count on even lines |
| cfg_we | input | 1 | Pattern write enable |
| cfg_pat | input | 2 | Pattern being written |
| cfg_idx | input | 5 | Field index within the pattern |
| cfg_data | input | 10 | Write data |
| vout | output | 8 | Vertical clock outputs |
| line_odd | output | 1 | Parity of the current line |

## Verification
Every result appears one clock after the edge that causes it. Outputs for a line start are valid in the cycle after the strobe edge, each toggle lands in the cycle in which the pass offset equals its position, and the second group begins one cycle after the qualifying pixel value was presented. The bench drives inputs while the clock is low and advances a behavioural model of that same edge. It then compares `vout` and `line_odd` against the model at the next falling edge, so every cycle yields exactly one comparison aligned to that one-cycle latency.

// File: rtl/vpat_line_seq.sv
module vpat_line_seq #(
  parameter int N_OUT = 8,
  parameter int N_PAT = 4,
  parameter int PIX_W = 10,
  parameter int REP_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     field_start,
  input  logic                     line_start,
  input  logic [PIX_W-1:0]         pix,
  input  logic                     sg_line,
  input  logic [$clog2(N_PAT)-1:0] sel_first,
  input  logic [$clog2(N_PAT)-1:0] sel_second,
  input  logic [REP_W-1:0]         rep_odd,
  input  logic [REP_W-1:0]         rep_even,
  input  logic                     cfg_we,
  input  logic [$clog2(N_PAT)-1:0] cfg_pat,
  input  logic [$clog2(2*N_OUT+2)-1:0] cfg_idx,
  input  logic [PIX_W-1:0]         cfg_data,
  output logic [N_OUT-1:0]         vout,
  output logic                     line_odd
);
  localparam int SEL_W   = $clog2(N_PAT);
  localparam int IDX_W   = $clog2(2*N_OUT+2);
  localparam int TI_W    = $clog2(2*N_OUT);
  localparam int POL_IDX = 2*N_OUT;
  localparam int LEN_IDX = 2*N_OUT+1;

  typedef enum logic [1:0] {PH_FIRST, PH_WAIT, PH_SECOND} phase_t;

  logic [PIX_W-1:0] tog  [N_PAT][2*N_OUT];
  logic [N_OUT-1:0] pol  [N_PAT];
  logic [PIX_W-1:0] plen [N_PAT];

  phase_t           phase;
  logic [SEL_W-1:0] cur_a, cur_b;
  logic             cur_sg, next_odd;
  logic [REP_W-1:0] reps_left;
  logic [PIX_W-1:0] pos;

  logic [SEL_W-1:0] act;
  logic [PIX_W:0]   pos_n;
  logic [N_OUT-1:0] hit;
  logic             odd_now, wrap;
  logic [REP_W-1:0] rep_now;

  assign act     = (phase == PH_SECOND) ? cur_b : cur_a;
  assign pos_n   = {1'b0, pos} + 1'b1;
  assign wrap    = pos_n >= {1'b0, plen[cur_a]};
  assign odd_now = field_start | next_odd;
  assign rep_now = odd_now ? rep_odd : rep_even;

  for (genvar j = 0; j < N_OUT; j++) begin : g_hit
    assign hit[j] = (pos_n == {1'b0, tog[act][2*j]}) ^ (pos_n == {1'b0, tog[act][2*j+1]});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < N_PAT; p++) begin
        pol[p]  <= '0;
        plen[p] <= '0;
        for (int i = 0; i < 2*N_OUT; i++) tog[p][i] <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_idx < IDX_W'(POL_IDX)) tog[cfg_pat][cfg_idx[TI_W-1:0]] <= cfg_data;
      else if (cfg_idx == IDX_W'(POL_IDX)) pol[cfg_pat] <= cfg_data[N_OUT-1:0];
      else if (cfg_idx == IDX_W'(LEN_IDX)) plen[cfg_pat] <= cfg_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_odd <= 1'b1;
      line_odd <= 1'b1;
    end else if (line_start) begin
      line_odd <= odd_now;
      next_odd <= ~odd_now;
    end else if (field_start) begin
      next_odd <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_WAIT;
      cur_a     <= '0;
      cur_b     <= '0;
      cur_sg    <= 1'b0;
      reps_left <= '0;
      pos       <= '0;
      vout      <= '0;
    end else if (line_start) begin
      cur_a     <= sel_first;
      cur_b     <= sel_second;
      cur_sg    <= sg_line;
      reps_left <= rep_now;
      pos       <= '0;
      vout      <= pol[sel_first];
      phase     <= (rep_now != '0) ? PH_FIRST : PH_WAIT;
    end else begin
      case (phase)
        PH_FIRST: begin
          if (wrap) begin
            pos       <= '0;
            vout      <= pol[cur_a];
            reps_left <= reps_left - 1'b1;
            if (reps_left == REP_W'(1)) phase <= PH_WAIT;
          end else begin
            pos  <= pos_n[PIX_W-1:0];
            vout <= vout ^ hit;
          end
        end
        PH_WAIT: begin
          if (cur_sg && pix >= plen[cur_b]) begin
            phase <= PH_SECOND;
            pos   <= '0;
            vout  <= pol[cur_b];
          end
        end
        default: begin
          if (!(&pos)) begin
            pos  <= pos_n[PIX_W-1:0];
            vout <= vout ^ hit;
          end
        end
      endcase
    end
  end

  assert_field_odd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && line_start) |=> line_odd);
  assert_live_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FIRST) |-> (reps_left != '0));
  assert_hold_after_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT && !cur_sg && !line_start) |=> $stable(vout));
  assert_zero_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && rep_now == '0) |=> (phase != PH_FIRST));
  assert_second_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT && !line_start && !cur_sg) |=> (phase == PH_WAIT));
  assert_second_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SECOND && !line_start) |=> (phase == PH_SECOND));
endmodule

// File: tb/test_vpat_line_seq.sv
`timescale 1ns/1ps
module test_vpat_line_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic field_start = 0, line_start = 0, sg_line = 0, cfg_we = 0;
  logic [9:0] pix = 0, cfg_data = 0;
  logic [1:0] sel_first = 0, sel_second = 0, cfg_pat = 0;
  logic [3:0] rep_odd = 0, rep_even = 0;
  logic [4:0] cfg_idx = 0;
  logic [7:0] vout;
  logic       line_odd;

  vpat_line_seq i_vpat_line_seq (.*);

  always #2.5 clk = ~clk;

  int vectors = 0, errors = 0;
  string tag = "R9";

  int b_tog [4][16];
  int b_pol [4];
  int b_len [4];

  int started = 0, m_k = 0, m_rep = 0, m_L = 1, m_pa = 0, m_pb = 0, m_sg = 0;
  int m_sec = 0, m_soff = 0, m_odd = 1, m_nxt = 1;

  function automatic logic [7:0] pat_out(int p, int o);
    logic [7:0] r;
    for (int j = 0; j < 8; j++) begin
      r[j] = b_pol[p][j];
      for (int s = 0; s < 2; s++)
        if (b_tog[p][2*j+s] > 0 && b_tog[p][2*j+s] <= o) r[j] = ~r[j];
    end
    return r;
  endfunction

  function automatic logic [7:0] expect_vout();
    if (!started) return 8'h00;
    if (m_k < m_rep * m_L) return pat_out(m_pa, m_k % m_L);
    if (m_sec) return pat_out(m_pb, m_soff);
    return b_pol[m_pa][7:0];
  endfunction

  task automatic compare();
    logic [7:0] e;
    e = expect_vout();
    vectors++;
    if (vout !== e || line_odd !== m_odd[0]) begin
      errors++;
      $display("FAIL %s: vout=%h line_odd=%b expected vout=%h line_odd=%0d", tag, vout, line_odd, e, m_odd);
    end
  endtask

  task automatic tick(input logic fs, input logic ls, input int pv);
    field_start = fs; line_start = ls; pix = 10'(pv);
    if (ls) begin
      m_odd = fs ? 1 : m_nxt;
      m_nxt = 1 - m_odd;
      started = 1; m_k = 0;
      m_rep = m_odd ? int'(rep_odd) : int'(rep_even);
      m_pa = sel_first; m_pb = sel_second; m_sg = sg_line;
      m_L = (b_len[m_pa] == 0) ? 1 : b_len[m_pa];
      m_sec = 0; m_soff = 0;
    end else begin
      if (fs) m_nxt = 1;
      if (started) begin
        if (m_sec) begin
          if (m_soff < 1023) m_soff++;
        end else if (m_k >= m_rep * m_L && m_sg && pv >= b_len[m_pb]) begin
          m_sec = 1; m_soff = 0;
        end
        m_k++;
      end
    end
    if (cfg_we) begin
      if (cfg_idx < 16) b_tog[cfg_pat][cfg_idx] = cfg_data;
      else if (cfg_idx == 16) b_pol[cfg_pat] = cfg_data[7:0];
      else if (cfg_idx == 17) b_len[cfg_pat] = cfg_data;
    end
    @(posedge clk);
    @(negedge clk);
    cfg_we = 0;
    compare();
  endtask

  task automatic wr(input int p, input int idx, input int d);
    cfg_we = 1; cfg_pat = 2'(p); cfg_idx = 5'(idx); cfg_data = 10'(d);
    tick(0, 0, 0);
  endtask

  task automatic run_line(input logic fs, input int n);
    tick(fs, 1, 0);
    for (int c = 1; c < n; c++) tick(0, 0, c);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++) begin
      b_pol[p] = 0; b_len[p] = 0;
      for (int i = 0; i < 16; i++) b_tog[p][i] = 0;
    end
    @(negedge clk);
    tag = "R9";
    compare();
    @(negedge clk);
    rst_n = 1;
    tick(0, 0, 0);
    tick(0, 0, 0);

    tag = "R1";
    for (int j = 0; j < 8; j++) begin
      wr(0, 2*j, (j % 5) + 1);  wr(0, 2*j+1, (j % 5) + 3);
      wr(1, 2*j, j + 1);        wr(1, 2*j+1, 8 - j);
      wr(2, 2*j, 2*j + 1);      wr(2, 2*j+1, 2*j + 4);
      wr(3, 2*j, 1);            wr(3, 2*j+1, 2);
    end
    wr(0, 16, 'hA5); wr(0, 17, 6);
    wr(1, 16, 'h0F); wr(1, 17, 9);
    wr(2, 16, 'h3C); wr(2, 17, 30);
    wr(3, 16, 'hFF); wr(3, 17, 0);
    wr(3, 20, 5);
    wr(3, 31, 7);

    tag = "R4"; rep_odd = 2; rep_even = 5; sel_first = 0;
    run_line(1, 50); run_line(0, 50); run_line(0, 50); run_line(0, 50);

    tag = "R2"; sel_first = 1; rep_odd = 3; rep_even = 1;
    run_line(0, 40); run_line(0, 40);
    sel_first = 3; rep_odd = 4; rep_even = 4;
    run_line(0, 12);

    tag = "R3"; sel_first = 0; rep_odd = 1; rep_even = 2;
    run_line(0, 20);
    tick(1, 0, 20);
    run_line(0, 20); run_line(0, 20); run_line(1, 20); run_line(0, 20);

    tag = "R5"; rep_odd = 2; rep_even = 0;
    run_line(1, 30); run_line(0, 30); run_line(0, 30);

    tag = "R6"; sg_line = 1; sel_second = 2; sel_first = 0; rep_odd = 2; rep_even = 2;
    run_line(1, 80);
    sel_first = 1; rep_even = 5;
    run_line(0, 80);
    tag = "R7";
    run_line(0, 90);

    tag = "R8"; sg_line = 0; sel_first = 1; rep_odd = 5; rep_even = 5;
    run_line(0, 13); run_line(0, 4); run_line(0, 60);

    tag = "R10"; sel_first = 0; rep_odd = 2; rep_even = 2; sg_line = 0;
    tick(1, 1, 0);
    sel_first = 1; rep_odd = 7; rep_even = 7; sg_line = 1; sel_second = 2;
    for (int c = 1; c < 60; c++) tick(0, 0, c);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule